// File: doc/BRIEF.md
# SPI Burst Register-Access Slave

This block sits behind an SPI slave port and turns each chip-select framed transaction into a burst of accesses on a byte-wide register bus. The master always opens a frame with two header bytes. The first byte is the start address. The second byte carries the transfer direction and a byte count. After the header, the data bytes follow. They flow into the register bus on a write and come out of it on a read.

While the master shifts the header in, the block returns a 12-bit status word taken from an input port. A master can end a frame after the address byte alone to fetch only the leading status bits. The SPI lines are brought into the system clock domain through a synchronizer. The block samples MOSI on rising SCLK, changes MISO on falling SCLK, and releases MISO through an output enable whenever chip select is high.

Top module: `spi_burst_slave`

## Requirements
- R1: While reset is asserted, `miso_oe`, `reg_wr` and `reg_rd` are low and `reg_addr` is 0x00.
- R2: In each frame the 16 MISO bit times of the two header bytes carry four 0 bits and then the `status` value sampled when chip select fell, sent MSB first. MISO holds the first bit before the first rising SCLK edge and changes only after falling SCLK edges.
- R3: `miso_oe` is low whenever chip select is high.
- R4: A frame that ends after exactly 8 bits is legal. It returns 0000 followed by status[11:8] and issues no register strobe.
- R5: In the second byte, bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 6:0 give the data byte count, and the value 0 means 128.
- R6: On a write, each completed data byte gives one `reg_wr` pulse with `reg_wdata` equal to the byte. Addresses run from the start address upward by one and wrap from 0xFF to 0x00. MISO reads 0x00 during write data bytes.
- R7: On a read, data byte k on MISO equals the register at start address + k (mod 256). Each byte is fetched by one `reg_rd` pulse issued at the preceding byte boundary. MOSI is ignored and causes no write.
- R8: Data bytes beyond the count cause no strobe and read as 0x00 on MISO.
- R9: If chip select rises within a byte, that byte gives no write. The next frame starts again with the address byte.
- R10: `reg_wr` and `reg_rd` are one-clock pulses and never high together. `reg_rdata` is taken in the clock cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI clock from master, idle low |
| csn | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| status | input | 12 | Status word returned during the header |
| reg_addr | output | 8 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid the cycle after `reg_rd` |

## Verification
A count field of zero has to run a full 128-byte burst. A design that decoded it literally would stop after no bytes or stop one short. Bursts that start at 0xFE and 0xFD must wrap to 0x00, and a carry into a ninth bit would send those bytes to the wrong registers. A frame is cut short four bits into a data byte to make sure that no half-received byte reaches the bus, and a read frame follows it to show that the header is decoded afresh. Bursts that run past their count and a frame that ends after the address byte catch a design that keeps strobing or that demands a length byte.

// File: rtl/spi_burst_slave.sv
module spi_burst_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                csn,
  input  logic                mosi,
  output logic                miso,
  output logic                miso_oe,
  input  logic [STATUS_W-1:0] status,
  output logic [7:0]          reg_addr,
  output logic [7:0]          reg_wdata,
  output logic                reg_wr,
  output logic                reg_rd,
  input  logic [7:0]          reg_rdata
);
  localparam int HDR_W   = 16;
  localparam int PAD_W   = HDR_W - STATUS_W;
  localparam int CNT_W   = 7;
  localparam int MAX_LEN = 1 << CNT_W;

  typedef enum logic [1:0] {S_ADDR, S_LEN, S_DATA, S_DONE} st_t;

  logic [2:0] sy [SYNC_STAGES];
  logic csn_s, sclk_s, mosi_s, sclk_d, csn_d;
  logic rise, fall, start;

  st_t        state;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sr, rx_byte, rem, addr_q, tx_buf, nxt_byte;
  logic [HDR_W-1:0] tx_sr;
  logic dir_wr, rd_pend, oe_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sy[i] <= 3'b100;
    end else begin
      sy[0] <= {csn, sclk, mosi};
      for (int i = 1; i < SYNC_STAGES; i++) sy[i] <= sy[i-1];
    end

  assign csn_s   = sy[SYNC_STAGES-1][2];
  assign sclk_s  = sy[SYNC_STAGES-1][1];
  assign mosi_s  = sy[SYNC_STAGES-1][0];
  assign rise    = sclk_s & ~sclk_d & ~csn_s;
  assign fall    = ~sclk_s & sclk_d & ~csn_s;
  assign start   = csn_d & ~csn_s;
  assign rx_byte = {rx_sr[6:0], mosi_s};
  assign nxt_byte = dir_wr ? 8'h00 : tx_buf;

  assign miso     = tx_sr[HDR_W-1] & oe_q;
  assign miso_oe  = oe_q;
  assign reg_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_d <= 1'b0;  csn_d <= 1'b1;  oe_q <= 1'b0;
      state <= S_ADDR; bit_cnt <= '0;  rx_sr <= '0;
      rem <= '0;       addr_q <= '0;   dir_wr <= 1'b0;
      reg_wr <= 1'b0;  reg_rd <= 1'b0; reg_wdata <= '0;
      rd_pend <= 1'b0; tx_buf <= '0;   tx_sr <= '0;
    end else begin
      sclk_d  <= sclk_s;
      csn_d   <= csn_s;
      oe_q    <= ~csn_s;
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      rd_pend <= reg_rd;
      if (rd_pend) tx_buf <= reg_rdata;
      if (reg_wr || reg_rd) addr_q <= addr_q + 8'd1;

      if (csn_s) begin
        state   <= S_ADDR;
        bit_cnt <= '0;
      end else if (rise) begin
        rx_sr   <= rx_byte;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          case (state)
            S_ADDR: begin
              addr_q <= rx_byte;
              state  <= S_LEN;
            end
            S_LEN: begin
              dir_wr <= rx_byte[7];
              rem    <= (rx_byte[CNT_W-1:0] == '0) ? 8'(MAX_LEN) : {1'b0, rx_byte[CNT_W-1:0]};
              reg_rd <= ~rx_byte[7];
              state  <= S_DATA;
            end
            S_DATA: begin
              rem <= rem - 8'd1;
              if (rem == 8'd1) state <= S_DONE;
              if (dir_wr) begin
                reg_wr    <= 1'b1;
                reg_wdata <= rx_byte;
              end else if (rem != 8'd1) begin
                reg_rd <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end

      if (start)
        tx_sr <= {{PAD_W{1'b0}}, status};
      else if (fall) begin
        if (bit_cnt == 3'd0 && state == S_DATA)
          tx_sr <= {nxt_byte, 8'h00};
        else
          tx_sr <= {tx_sr[HDR_W-2:0], 1'b0};
      end
    end

  p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !miso_oe);

  p_hdr_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn_s) |=> (miso_oe && !miso));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> !(reg_wr || reg_rd));

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> reg_addr == $past(reg_addr) + 8'd1);

  p_rdata_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> tx_buf == $past(reg_rdata));

  p_wr_in_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ($past(state) == S_DATA && $past(dir_wr)));

  p_quiet_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_DONE) |-> !(reg_wr || reg_rd));

  p_rem_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (rem != 8'd0 && rem <= 8'(MAX_LEN)));
endmodule

// File: tb/spi_burst_slave_bench.sv
module spi_burst_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NVEC       = 6;

  // {addr, ctrl, seed, pad, status}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h10, 8'h84, 8'hA0, 4'h0, 12'h5A3},
    {8'h10, 8'h04, 8'h55, 4'h0, 12'h011},
    {8'hFE, 8'h83, 8'h30, 4'h0, 12'hFFF},
    {8'hFD, 8'h05, 8'hFF, 4'h0, 12'h000},
    {8'h40, 8'h80, 8'h00, 4'h0, 12'h812},
    {8'h40, 8'h02, 8'hC3, 4'h0, 12'h7E4}
  };

  logic clk = 0, rst_n = 0, sclk = 0, csn = 1, mosi = 0;
  logic miso, miso_oe, reg_wr, reg_rd;
  logic [11:0] status = '0;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  spi_burst_slave u_spi_burst_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .status(status),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [256];
  logic [7:0] wa [1024];
  logic [7:0] wd [1024];
  int wn = 0, rn = 0, bad_strobe = 0;
  logic prev_strobe = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        mem[reg_addr] <= reg_wdata;
        wa[wn] <= reg_addr;
        wd[wn] <= reg_wdata;
        wn <= wn + 1;
      end
      if (reg_rd) begin
        reg_rdata <= mem[reg_addr];
        rn <= rn + 1;
      end
      if ((reg_wr && reg_rd) || ((reg_wr || reg_rd) && prev_strobe)) bad_strobe <= bad_strobe + 1;
      prev_strobe <= reg_wr || reg_rd;
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] txb [140];
  logic [7:0] rxb [140];
  logic [7:0] expb [140];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input int nbits);
    @(negedge clk);
    csn = 0;
    for (int i = 0; i < nbits; i++) begin
      mosi = txb[i/8][7-(i%8)];
      repeat (HALF) @(negedge clk);
      rxb[i/8][7-(i%8)] = miso;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1;
    repeat (3*HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 140; i++) begin txb[i] = '0; rxb[i] = '0; expb[i] = '0; end
    repeat (5) @(negedge clk);
    chk(miso_oe == 0, "R1", 32'(miso_oe), 0);
    chk(!reg_wr && !reg_rd, "R1", {reg_wr, reg_rd}, 0);
    chk(reg_addr == 8'h00, "R1", 32'(reg_addr), 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(miso_oe == 0, "R3", 32'(miso_oe), 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] a, c, s;
      logic [11:0] st;
      int n, w0, r0;
      {a, c, s} = VEC[v][39:16];
      st = VEC[v][11:0];
      n = (c[6:0] == 0) ? 128 : int'(c[6:0]);
      status = st;
      txb[0] = a; txb[1] = c;
      for (int k = 0; k < n; k++) begin
        txb[2+k] = 8'(s + k);
        expb[k] = mem[8'(a + k)];
      end
      w0 = wn; r0 = rn;
      run_frame(16 + 8*n);
      chk({rxb[0], rxb[1]} == {4'h0, st}, "R2", {rxb[0], rxb[1]}, {4'h0, st});
      if (c[7]) begin
        chk(wn - w0 == n, "R5", wn - w0, n);
        for (int k = 0; k < n; k++) begin
          chk(wa[w0+k] == 8'(a + k), "R6", wa[w0+k], 8'(a + k));
          chk(wd[w0+k] == 8'(s + k), "R6", wd[w0+k], 8'(s + k));
          chk(rxb[2+k] == 8'h00, "R6", rxb[2+k], 0);
        end
      end else begin
        chk(rn - r0 == n, "R5", rn - r0, n);
        chk(wn == w0, "R7", wn - w0, 0);
        for (int k = 0; k < n; k++)
          chk(rxb[2+k] == expb[k], "R7", rxb[2+k], expb[k]);
      end
    end

    // R4: address-only frame
    begin
      int w0, r0;
      status = 12'hA5C; txb[0] = 8'h33;
      w0 = wn; r0 = rn;
      run_frame(8);
      chk(rxb[0] == 8'h0A, "R4", rxb[0], 8'h0A);
      chk(wn == w0 && rn == r0, "R4", (wn - w0) + (rn - r0), 0);
    end

    // R9: abort within the second data byte, then a fresh read frame
    begin
      int w0;
      logic [7:0] keep;
      keep = mem[8'h21];
      status = 12'h3C6;
      txb[0] = 8'h20; txb[1] = 8'h82; txb[2] = 8'h11; txb[3] = 8'h22;
      w0 = wn;
      run_frame(16 + 8 + 4);
      chk(wn - w0 == 1, "R9", wn - w0, 1);
      chk(wa[w0] == 8'h20 && wd[w0] == 8'h11, "R9", {wa[w0], wd[w0]}, 16'h2011);
      txb[0] = 8'h21; txb[1] = 8'h01; txb[2] = 8'h00;
      run_frame(24);
      chk({rxb[0], rxb[1]} == 16'h03C6, "R9", {rxb[0], rxb[1]}, 16'h03C6);
      chk(rxb[2] == keep, "R9", rxb[2], keep);
    end

    // R8: bytes beyond the count
    begin
      int w0, r0;
      txb[0] = 8'h50; txb[1] = 8'h81; txb[2] = 8'h77; txb[3] = 8'h88; txb[4] = 8'h99;
      w0 = wn;
      run_frame(40);
      chk(wn - w0 == 1, "R8", wn - w0, 1);
      chk(rxb[3] == 0 && rxb[4] == 0, "R8", {rxb[3], rxb[4]}, 0);
      txb[1] = 8'h01;
      r0 = rn; w0 = wn;
      run_frame(40);
      chk(rn - r0 == 1 && wn == w0, "R8", rn - r0, 1);
      chk(rxb[2] == 8'h77, "R8", rxb[2], 8'h77);
      chk(rxb[3] == 0 && rxb[4] == 0, "R8", {rxb[3], rxb[4]}, 0);
    end

    chk(bad_strobe == 0, "R10", bad_strobe, 0);
    chk(miso_oe == 0, "R3", 32'(miso_oe), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule